// File: doc/BRIEF.md
# Transmit Phase-Compensation FIFO with Self Re-centring

This block is a four-entry elastic buffer that sits between a parallel transmit data path and a serialiser. Words arrive on a system write clock, one word per write-clock edge, and leave one word per edge of a read clock that comes from the transmitter's clock multiplier. Both clocks run at the same nominal rate. Their phase relationship is unknown, and it may wander within a bounded range. The buffer has no full or empty handshake. It relies on the two pointers being placed half the storage apart when it starts, and on their distance then staying within bounds.

A reset input must be held high for at least two read-clock cycles. After it falls, the read side flushes for a fixed time and then locks the read pointer at a set distance behind the synchronised write pointer. From that point on it delivers words. If the phase drift grows until the two pointers meet, the block raises an overflow flag and stops delivering data. The overflow flag then stays high until the next reset. When the auto-recovery input is high, the block instead clears the overflow itself and repeats the flush-and-lock sequence without outside help.

The read-side controller is a state machine with five states:
- ST_HOLD: reset is active.
- ST_FLUSH: the fixed wait runs.
- ST_LOCK: the read pointer is placed.
- ST_RUN: data is delivered.
- ST_FAULT: the pointers have collided.

It has these transitions:
- HOLD to FLUSH: on the first cycle after the synchronised reset is released.
- FLUSH to LOCK: when the flush count expires.
- LOCK to RUN: always, on the next cycle.
- RUN to FAULT: on a collision.
- FAULT to FLUSH: when auto recovery is enabled.
- Any state to HOLD: whenever reset is asserted.

Top module: `txfifo_phase_comp`

## Requirements
- R1: While fifo_rst is high, and afterwards until centring completes, rd_valid is 0, overflow is 0 and rd_data is all zeros.
- R2: With fifo_rst held high for at least 2 rd_clk cycles, rd_valid becomes 1 between 8 and 10 rd_clk rising edges after fifo_rst falls, with 9 as the nominal value.
- R3: Once centred, with equal clock rates and any fixed phase offset, successive rd_data samples are the words written on successive wr_clk edges, in order, with none lost and none repeated. An incrementing write pattern therefore reads back with each sample equal to the previous one plus 1 modulo 2^W.
- R4: After centring, a relative slip of one word in either direction does not set overflow, and rd_valid stays 1. A slip is the write clock losing one edge or gaining one extra edge.
- R5: A relative slip of two or more words in either direction brings the read pointer onto the synchronised write pointer, and overflow becomes 1.
- R6: With auto_rst_en at 0, overflow stays 1 once set, while rd_valid stays 0 and rd_data stays zero, until fifo_rst is asserted.
- R7: A reset after an overflow clears overflow and centres the FIFO again within the R2 window.
- R8: With auto_rst_en at 1, an overflow is high for at least one rd_clk cycle and then clears without a reset. rd_valid returns within 10 rd_clk cycles of the overflow, and data is then delivered in order as in R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | System transmit word clock (write side) |
| wr_data | input | W | Word written on every wr_clk rising edge |
| rd_clk | input | 1 | Clock derived from the clock multiplier (read side) |
| fifo_rst | input | 1 | Asynchronous FIFO reset, active high |
| auto_rst_en | input | 1 | 1: recover from overflow automatically |
| rd_data | output | W | Word read on the rd_clk side; zero when not centred |
| rd_valid | output | 1 | 1 while the FIFO is centred and delivering |
| overflow | output | 1 | Pointer collision detected (sticky unless auto recovery) |

## Verification
A wrong lock offset shows up at the ports in one of two ways. Either a one-word slip raises overflow within a few read cycles, or a word is read back twice or skipped in the incrementing pattern, which breaks the plus-one sequence on the very first centred sample. A flush counter that is off by one moves the rising edge of rd_valid outside the 8 to 10 edge window. A fault state that does not hold, or one that leaves wrongly, shows up within a single read cycle: in manual mode overflow falls, and in automatic mode it stays high.

// File: rtl/txf_pkg.sv
package txf_pkg;

    typedef enum logic [2:0] {
        ST_HOLD,
        ST_FLUSH,
        ST_LOCK,
        ST_RUN,
        ST_FAULT
    } txf_state_e;

endpackage

// File: rtl/txf_rst_sync.sv
module txf_rst_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic arst_in,
    output logic rst_out
);

    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or posedge arst_in) begin
        if (arst_in) begin
            chain <= '1;
        end else begin
            chain <= {chain[STAGES-2:0], 1'b0};
        end
    end

    assign rst_out = chain[STAGES-1];

endmodule

// File: rtl/txf_ptr_sync.sv
module txf_ptr_sync #(
    parameter int AW = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] gray_in,
    output logic [AW-1:0] bin_out
);

    logic [AW-1:0] meta_q;
    logic [AW-1:0] sync_q;

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= gray_in;
            sync_q <= meta_q;
        end
    end

    always_comb begin
        bin_out[AW-1] = sync_q[AW-1];
        for (int i = AW - 2; i >= 0; i--) begin
            bin_out[i] = bin_out[i+1] ^ sync_q[i];
        end
    end

endmodule

// File: rtl/txf_write_side.sv
module txf_write_side #(
    parameter int W  = 8,
    parameter int AW = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [W-1:0]  din,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  dout,
    output logic [AW-1:0] wgray
);

    localparam int DEPTH = 1 << AW;

    logic [W-1:0]  store [DEPTH];
    logic [AW-1:0] wptr;
    logic [AW-1:0] wptr_nxt;

    assign wptr_nxt = wptr + 1'b1;

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            wptr  <= '0;
            wgray <= '0;
        end else begin
            wptr  <= wptr_nxt;
            wgray <= wptr_nxt ^ (wptr_nxt >> 1);
        end
    end

    always_ff @(posedge clk) begin
        store[wptr] <= din;
    end

    assign dout = store[raddr];

    // R3: the pointer seen by the read domain moves one bit at a time
    a_r3_gray_step: assert property (@(posedge clk) disable iff (rst)
        !$stable(wgray) |-> $countones(wgray ^ $past(wgray)) == 1);

endmodule

// File: rtl/txf_read_ctrl.sv
module txf_read_ctrl
    import txf_pkg::*;
#(
    parameter int AW        = 2,
    parameter int FLUSH_CYC = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          auto_en,
    input  logic [AW-1:0] wsync_bin,
    output logic [AW-1:0] raddr,
    output logic          centred,
    output logic          overflow
);

    localparam int            DEPTH = 1 << AW;
    localparam int            CW    = $clog2(FLUSH_CYC + 1);
    localparam logic [AW-1:0] LEAD  = AW'(DEPTH / 2);
    localparam logic [CW-1:0] LAST  = CW'(FLUSH_CYC - 1);

    txf_state_e    state, nxt;
    logic [CW-1:0] cnt;
    logic [AW-1:0] rptr;
    logic          collide;

    assign collide = (wsync_bin == rptr);

    always_comb begin
        nxt = state;
        unique case (state)
            ST_HOLD:  nxt = ST_FLUSH;
            ST_FLUSH: if (cnt == LAST) nxt = ST_LOCK;
            ST_LOCK:  nxt = ST_RUN;
            ST_RUN:   if (collide) nxt = ST_FAULT;
            ST_FAULT: if (auto_en) nxt = ST_FLUSH;
            default:  nxt = ST_HOLD;
        endcase
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            state <= ST_HOLD;
            cnt   <= '0;
            rptr  <= '0;
        end else begin
            state <= nxt;
            cnt   <= (state == ST_FLUSH) ? cnt + 1'b1 : '0;
            if (state == ST_LOCK) begin
                rptr <= wsync_bin + 1'b1 - LEAD;
            end else if (state == ST_RUN) begin
                rptr <= rptr + 1'b1;
            end
        end
    end

    always_comb begin
        centred  = 1'b0;
        overflow = 1'b0;
        unique case (state)
            ST_RUN:   centred  = 1'b1;
            ST_FAULT: overflow = 1'b1;
            default:  ;
        endcase
    end

    assign raddr = rptr + LEAD;

    // R5: a collision can only be flagged out of centred operation
    a_r5_fault_from_run: assert property (@(posedge clk) disable iff (rst)
        $rose(overflow) |-> $past(centred));

    // R6: without auto recovery the flag holds
    a_r6_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
        overflow && !auto_en |=> overflow);

    // R8: with auto recovery the fault is left on the next cycle
    a_r8_auto_exit: assert property (@(posedge clk) disable iff (rst)
        overflow && auto_en |=> !overflow && !centred);

endmodule

// File: rtl/txfifo_phase_comp.sv
module txfifo_phase_comp #(
    parameter int W         = 8,
    parameter int AW        = 2,
    parameter int FLUSH_CYC = 5
) (
    input  logic         wr_clk,
    input  logic [W-1:0] wr_data,
    input  logic         rd_clk,
    input  logic         fifo_rst,
    input  logic         auto_rst_en,
    output logic [W-1:0] rd_data,
    output logic         rd_valid,
    output logic         overflow
);

    logic          rst_wr;
    logic          rst_rd;
    logic [AW-1:0] wgray;
    logic [AW-1:0] wsync_bin;
    logic [AW-1:0] raddr;
    logic [W-1:0]  mem_out;

    txf_rst_sync #(.STAGES(2)) u_rst_wr (
        .clk     (wr_clk),
        .arst_in (fifo_rst),
        .rst_out (rst_wr)
    );

    txf_rst_sync #(.STAGES(2)) u_rst_rd (
        .clk     (rd_clk),
        .arst_in (fifo_rst),
        .rst_out (rst_rd)
    );

    txf_write_side #(.W(W), .AW(AW)) u_wr (
        .clk   (wr_clk),
        .rst   (rst_wr),
        .din   (wr_data),
        .raddr (raddr),
        .dout  (mem_out),
        .wgray (wgray)
    );

    txf_ptr_sync #(.AW(AW)) u_sync (
        .clk     (rd_clk),
        .rst     (rst_rd),
        .gray_in (wgray),
        .bin_out (wsync_bin)
    );

    txf_read_ctrl #(.AW(AW), .FLUSH_CYC(FLUSH_CYC)) u_rd (
        .clk       (rd_clk),
        .rst       (rst_rd),
        .auto_en   (auto_rst_en),
        .wsync_bin (wsync_bin),
        .raddr     (raddr),
        .centred   (rd_valid),
        .overflow  (overflow)
    );

    assign rd_data = rd_valid ? mem_out : '0;

endmodule

// File: tb/sim_txfifo_phase_comp.sv
`timescale 1ns/10ps
module sim_txfifo_phase_comp;

    localparam int W = 8;

    logic         wr_clk;
    logic         rd_clk;
    logic [W-1:0] wr_data;
    logic         fifo_rst;
    logic         auto_rst_en;
    logic [W-1:0] rd_data;
    logic         rd_valid;
    logic         overflow;

    int   n_chk  = 0;
    int   n_fail = 0;
    int   skip_n = 0;
    int   extra_n = 0;
    real  shift_ns = 0.0;

    txfifo_phase_comp #(.W(W), .AW(2), .FLUSH_CYC(5)) u0 (
        .wr_clk      (wr_clk),
        .wr_data     (wr_data),
        .rd_clk      (rd_clk),
        .fifo_rst    (fifo_rst),
        .auto_rst_en (auto_rst_en),
        .rd_data     (rd_data),
        .rd_valid    (rd_valid),
        .overflow    (overflow)
    );

    // 200 MHz read clock
    initial begin
        rd_clk = 1'b0;
        forever #2.5 rd_clk = ~rd_clk;
    end

    // write clock: same rate, offset phase, with slips on request
    initial begin
        wr_clk = 1'b0;
        #1.1;
        forever begin
            if (shift_ns > 0.0) begin
                #(shift_ns);
                shift_ns = 0.0;
            end
            if (skip_n > 0) begin
                skip_n = skip_n - 1;
                #5;
            end else if (extra_n > 0) begin
                extra_n = extra_n - 1;
                wr_clk = 1'b1; #1.25; wr_clk = 1'b0; #1.25;
                wr_clk = 1'b1; #1.25; wr_clk = 1'b0; #1.25;
            end else begin
                wr_clk = 1'b1; #2.5; wr_clk = 1'b0; #2.5;
            end
        end
    end

    initial wr_data = '0;
    always @(negedge wr_clk) wr_data <= wr_data + 1'b1;

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // reset with R1 / R2 checks; returns edges to centring
    task automatic do_reset(input string req);
        int k;
        int bad;
        fifo_rst = 1'b1;
        repeat (3) @(negedge rd_clk);
        chk(!rd_valid && !overflow && rd_data == 0, "R1 in reset",
            {rd_valid, overflow, (rd_data != 0)}, 0);
        fifo_rst = 1'b0;
        k   = 0;
        bad = 0;
        while (!rd_valid && k < 20) begin
            @(negedge rd_clk);
            k++;
            if (!rd_valid && (rd_data != 0 || overflow)) bad++;
        end
        chk(bad == 0, "R1 during flush", bad, 0);
        chk(k >= 8 && k <= 10, req, k, 9);
    endtask

    task automatic check_order(input string req, input int n);
        int bad;
        logic [W-1:0] prev;
        bad  = 0;
        @(negedge rd_clk);
        prev = rd_data;
        for (int i = 0; i < n; i++) begin
            @(negedge rd_clk);
            if (!rd_valid || rd_data != prev + 1'b1) bad++;
            prev = rd_data;
        end
        chk(bad == 0, req, bad, 0);
    endtask

    initial begin
        #500000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=1 expected=0");
        summary();
    end

    initial begin
        fifo_rst    = 1'b1;
        auto_rst_en = 1'b0;

        // R2 / R3: sweep of fixed phase offsets
        for (int p = 0; p < 4; p++) begin
            if (p > 0) begin
                shift_ns = 1.2;
                repeat (3) @(negedge rd_clk);
            end
            do_reset("R2 centring latency");
            check_order("R3 in-order delivery", 30);
        end

        // R4 / R5 / R6 / R7: slip sweep, both directions, 1..3 words
        for (int dir = 0; dir < 2; dir++) begin
            for (int n = 1; n <= 3; n++) begin
                int bad;
                do_reset("R7 recentre latency");
                repeat (4) @(negedge rd_clk);
                if (dir == 0) skip_n = n; else extra_n = n;
                wait (skip_n == 0 && extra_n == 0);
                repeat (12) @(negedge rd_clk);
                if (n == 1) begin
                    chk(!overflow, "R4 one-word slip no overflow", overflow, 0);
                    chk(rd_valid, "R4 still centred", rd_valid, 1);
                end else begin
                    chk(overflow, "R5 collision flagged", overflow, 1);
                    bad = 0;
                    for (int i = 0; i < 20; i++) begin
                        @(negedge rd_clk);
                        if (!overflow || rd_valid || rd_data != 0) bad++;
                    end
                    chk(bad == 0, "R6 sticky overflow", bad, 0);
                    do_reset("R7 recentre after overflow");
                    chk(!overflow, "R7 overflow cleared", overflow, 0);
                    check_order("R7 in-order after reset", 20);
                end
            end
        end

        // R8: automatic recovery
        auto_rst_en = 1'b1;
        do_reset("R2 centring latency auto");
        repeat (4) @(negedge rd_clk);
        skip_n = 2;
        wait (skip_n == 0);
        begin
            int k;
            int seen;
            int back;
            seen = 0;
            k    = 0;
            while (!seen && k < 20) begin
                @(negedge rd_clk);
                k++;
                if (overflow) seen = 1;
            end
            chk(seen == 1, "R8 overflow seen", seen, 1);
            back = 0;
            while (!rd_valid && back < 20) begin
                @(negedge rd_clk);
                back++;
            end
            chk(back <= 10, "R8 recovery time", back, 7);
            chk(!overflow, "R8 overflow cleared", overflow, 0);
        end
        check_order("R8 in-order after recovery", 30);

        summary();
    end

endmodule